// File: doc/BRIEF.md
# Instruction Pairing Detector

This block watches the stream of retiring instructions of an in-order core and decides, for each retiring instruction, whether it overlaps with the one retired before it. When it does, the cycle accounting logic can charge the second instruction a shorter cycle count. The decoder delivers each instruction already reduced to a 7-bit family code. The block keeps the family of the previous retired instruction in a register. On each retire strobe it evaluates the ordered pair (previous, current) against a fixed, directional compatibility relation and registers the outcome as a pairing flag. It then stores the current family as the new previous one.

The relation is built from groups rather than a full square table. Any of the eight shift/rotate families pairs with one shared list of followers. Exchange, compare, bit test, multiply, add/subtract and BCD arithmetic each have their own short list of partners. Every ordered pair not covered by one of these rules does not pair. A synchronous flush returns the tracker to the state it has after reset, for example after an exception or a pipeline redirect.

Top module: `pair_detect_top`

## Requirements
- R1: While reset is asserted and after it is released, `prev_family_o` is the no-operation code 0 and `paired_o` is 0.
- R2: Family codes: 0 no-op, 1 exchange, 2 decrement-and-branch, 3 move, 4 move-to-address, 5 compare, 6 compare-address, 7 conditional branch, 8 bit test, 9 load-effective-address, 10 jump, 11 jump-to-subroutine, 12 unsigned multiply, 13 signed multiply, 14 unsigned divide, 15 signed divide, 16 add, 17 subtract, 18 OR, 19 AND, 20 XOR, 21 NOT, 22 clear, 23 negate, 24 add-extended, 25 subtract-extended, 26 BCD add, 27 BCD subtract, 32 to 39 the eight shift/rotate families. Codes 28-31 and 40-127 are unused. One cycle after a retire, `prev_family_o` equals the retired code.
- R3: A previous family in 32..39, followed by any of codes 2, 3, 4, 9, 10 or 16..27, pairs.
- R4: Exchange (1) followed by 2, 3 or 4 pairs.
- R5: Compare (5), compare-address (6) or bit test (8), followed by conditional branch (7), pairs.
- R6: Multiply (12 or 13) followed by 3, 4, 14, 15 or 11 pairs.
- R7: Add (16) or subtract (17) followed by move (3) pairs. BCD add (26) or BCD subtract (27) followed by decrement-and-branch (2) pairs.
- R8: Every other ordered pair does not pair. This includes divide followed by multiply, divide followed by move, move followed by decrement-and-branch, and every pair that involves an unused code.
- R9: `paired_o` is registered on a retire and shows the result for the pair that retire formed, one cycle later. Without a retire, `paired_o` and `prev_family_o` hold their values whatever `family_i` does.
- R10: A flush sets `prev_family_o` to 0 and `paired_o` to 0 on the next cycle. A flush takes priority over a retire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | An instruction retires this cycle |
| family_i | input | 7 | Family code of the retiring instruction |
| flush_i | input | 1 | Synchronous return to the reset state |
| paired_o | output | 1 | Last retired instruction paired with its predecessor |
| prev_family_o | output | 7 | Family of the last retired instruction |

## Verification
The assertions take for granted that `retire_i` and `flush_i` are valid in every cycle after reset. They make no assumption about `family_i`: unused codes may appear and must be treated as non-pairing, and the value on the bus is ignored when no retire occurs. The stimulus therefore sweeps all 128 × 128 ordered code pairs, including the unused ones. Between retires it changes `family_i` during idle cycles, and it raises a flush together with a retire so that the priority case is exercised.

// File: rtl/pair_pkg.sv
package pair_pkg;

  localparam int unsigned FAM_W = 7;

  typedef logic [FAM_W-1:0] fam_t;

  localparam fam_t FAM_NOP   = fam_t'(0);
  localparam fam_t FAM_EXG   = fam_t'(1);
  localparam fam_t FAM_DBR   = fam_t'(2);
  localparam fam_t FAM_MOV   = fam_t'(3);
  localparam fam_t FAM_MOVA  = fam_t'(4);
  localparam fam_t FAM_CMP   = fam_t'(5);
  localparam fam_t FAM_CMPA  = fam_t'(6);
  localparam fam_t FAM_BCND  = fam_t'(7);
  localparam fam_t FAM_BTST  = fam_t'(8);
  localparam fam_t FAM_LEA   = fam_t'(9);
  localparam fam_t FAM_JMP   = fam_t'(10);
  localparam fam_t FAM_JSUB  = fam_t'(11);
  localparam fam_t FAM_MULU  = fam_t'(12);
  localparam fam_t FAM_MULS  = fam_t'(13);
  localparam fam_t FAM_DIVU  = fam_t'(14);
  localparam fam_t FAM_DIVS  = fam_t'(15);
  localparam fam_t FAM_ADD   = fam_t'(16);
  localparam fam_t FAM_SUB   = fam_t'(17);
  // 16..27 form a contiguous arithmetic/logic block that follows shifts
  localparam fam_t FAM_ALU_LO = fam_t'(16);
  localparam fam_t FAM_ALU_HI = fam_t'(27);
  localparam fam_t FAM_BCDA  = fam_t'(26);
  localparam fam_t FAM_BCDS  = fam_t'(27);

  localparam int unsigned SHIFT_BASE  = 32;
  localparam int unsigned SHIFT_COUNT = 8;

  // Role of a family when it is the earlier instruction of a pair
  typedef struct packed {
    logic shift;
    logic exg;
    logic cmp;
    logic btst;
    logic mul;
    logic addsub;
    logic bcd;
  } lead_role_t;

  // Role of a family when it is the later instruction of a pair
  typedef struct packed {
    logic shift_fol;
    logic dbr;
    logic mov;
    logic mova;
    logic bcnd;
    logic div;
    logic jsub;
  } follow_role_t;

endpackage

// File: rtl/pair_lead_class.sv
module pair_lead_class
  import pair_pkg::*;
#(
  parameter int unsigned SH_BASE  = SHIFT_BASE,
  parameter int unsigned SH_COUNT = SHIFT_COUNT
) (
  input  fam_t       fam_i,
  output lead_role_t role_o
);

  logic [SH_COUNT-1:0] sh_hit;

  for (genvar gi = 0; gi < SH_COUNT; gi++) begin : g_shift
    assign sh_hit[gi] = (fam_i == fam_t'(SH_BASE + gi));
  end

  always_comb begin
    role_o        = '0;
    role_o.shift  = |sh_hit;
    role_o.exg    = (fam_i == FAM_EXG);
    role_o.cmp    = (fam_i == FAM_CMP) || (fam_i == FAM_CMPA);
    role_o.btst   = (fam_i == FAM_BTST);
    role_o.mul    = (fam_i == FAM_MULU) || (fam_i == FAM_MULS);
    role_o.addsub = (fam_i == FAM_ADD) || (fam_i == FAM_SUB);
    role_o.bcd    = (fam_i == FAM_BCDA) || (fam_i == FAM_BCDS);
  end

  always_comb begin
    assert ($countones({role_o.shift, role_o.exg, role_o.cmp, role_o.btst,
                        role_o.mul, role_o.addsub, role_o.bcd}) <= 1)
      else $error("p_lead_onehot_r2: family in more than one lead group");
  end

endmodule

// File: rtl/pair_follow_class.sv
module pair_follow_class
  import pair_pkg::*;
(
  input  fam_t         fam_i,
  output follow_role_t role_o
);

  logic alu_blk;

  always_comb begin
    alu_blk          = (fam_i >= FAM_ALU_LO) && (fam_i <= FAM_ALU_HI);
    role_o           = '0;
    role_o.dbr       = (fam_i == FAM_DBR);
    role_o.mov       = (fam_i == FAM_MOV);
    role_o.mova      = (fam_i == FAM_MOVA);
    role_o.bcnd      = (fam_i == FAM_BCND);
    role_o.div       = (fam_i == FAM_DIVU) || (fam_i == FAM_DIVS);
    role_o.jsub      = (fam_i == FAM_JSUB);
    role_o.shift_fol = role_o.dbr || role_o.mov || role_o.mova ||
                       (fam_i == FAM_LEA) || (fam_i == FAM_JMP) || alu_blk;
  end

endmodule

// File: rtl/pair_rule_eval.sv
module pair_rule_eval
  import pair_pkg::*;
(
  input  lead_role_t   lead_i,
  input  follow_role_t fol_i,
  output logic         pair_o
);

  logic r_shift, r_exg, r_cmp, r_mul, r_arith;

  always_comb begin
    r_shift = lead_i.shift && fol_i.shift_fol;
    r_exg   = lead_i.exg && (fol_i.dbr || fol_i.mov || fol_i.mova);
    r_cmp   = (lead_i.cmp || lead_i.btst) && fol_i.bcnd;
    r_mul   = lead_i.mul && (fol_i.mov || fol_i.mova || fol_i.div || fol_i.jsub);
    r_arith = (lead_i.addsub && fol_i.mov) || (lead_i.bcd && fol_i.dbr);
    pair_o  = r_shift || r_exg || r_cmp || r_mul || r_arith;
  end

  always_comb begin
    if (fol_i.bcnd) begin
      assert (pair_o == (lead_i.cmp || lead_i.btst))
        else $error("p_branch_lead_r5: branch pairing mismatch");
    end
  end

endmodule

// File: rtl/pair_detect_top.sv
module pair_detect_top
  import pair_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic [FAM_W-1:0] family_i,
  input  logic             flush_i,
  output logic             paired_o,
  output logic [FAM_W-1:0] prev_family_o
);

  fam_t         prev_q, prev_d;
  logic         pair_q, pair_d;
  logic         state_en;
  lead_role_t   lead_role;
  follow_role_t fol_role;
  logic         pair_hit;

  pair_lead_class #(
    .SH_BASE (SHIFT_BASE),
    .SH_COUNT(SHIFT_COUNT)
  ) u_lead (
    .fam_i (prev_q),
    .role_o(lead_role)
  );

  pair_follow_class u_fol (
    .fam_i (family_i),
    .role_o(fol_role)
  );

  pair_rule_eval u_eval (
    .lead_i(lead_role),
    .fol_i (fol_role),
    .pair_o(pair_hit)
  );

  // next state
  always_comb begin
    state_en = flush_i || retire_i;
    prev_d   = prev_q;
    pair_d   = pair_q;
    if (flush_i) begin
      prev_d = FAM_NOP;
      pair_d = 1'b0;
    end else if (retire_i) begin
      prev_d = family_i;
      pair_d = pair_hit;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= FAM_NOP;
      pair_q <= 1'b0;
    end else if (state_en) begin
      prev_q <= prev_d;
      pair_q <= pair_d;
    end
  end

  assign paired_o      = pair_q;
  assign prev_family_o = prev_q;

  p_flush_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (prev_family_o == FAM_NOP) && !paired_o);

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_i && !flush_i) |=> $stable(prev_family_o) && $stable(paired_o));

  p_prev_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !flush_i) |=> prev_family_o == $past(family_i));

  p_div_mul_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !flush_i && (prev_family_o == FAM_DIVU || prev_family_o == FAM_DIVS)
     && (family_i == FAM_MULU || family_i == FAM_MULS)) |=> !paired_o);

  p_mov_dbr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !flush_i && prev_family_o == FAM_MOV && family_i == FAM_DBR)
      |=> !paired_o);

  p_mul_div_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !flush_i && (prev_family_o == FAM_MULU || prev_family_o == FAM_MULS)
     && (family_i == FAM_DIVU || family_i == FAM_DIVS)) |=> paired_o);

  p_nop_lead_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !flush_i && prev_family_o == FAM_NOP) |=> !paired_o);

endmodule

// File: tb/pair_detect_top_tb.sv
module pair_detect_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       retire_i;
  logic [6:0] family_i;
  logic       flush_i;
  logic       paired_o;
  logic [6:0] prev_family_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pair_detect_top u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .retire_i     (retire_i),
    .family_i     (family_i),
    .flush_i      (flush_i),
    .paired_o     (paired_o),
    .prev_family_o(prev_family_o)
  );

  function automatic bit in_shift(int f);
    return f >= 32 && f <= 39;
  endfunction

  function automatic bit shift_follower(int f);
    return f == 2 || f == 3 || f == 4 || f == 9 || f == 10 || (f >= 16 && f <= 27);
  endfunction

  // returns expected pairing; tag names the deciding requirement
  function automatic bit model(int p, int c, output string tag);
    tag = "R8";
    if (in_shift(p)) begin
      tag = "R3"; return shift_follower(c);
    end
    if (p == 1) begin
      tag = "R4"; return c == 2 || c == 3 || c == 4;
    end
    if (p == 5 || p == 6 || p == 8) begin
      tag = "R5"; return c == 7;
    end
    if (p == 12 || p == 13) begin
      tag = "R6"; return c == 3 || c == 4 || c == 14 || c == 15 || c == 11;
    end
    if (p == 16 || p == 17) begin
      tag = "R7"; return c == 3;
    end
    if (p == 26 || p == 27) begin
      tag = "R7"; return c == 2;
    end
    return 1'b0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at negedge, state updates at posedge, sample at following negedge
  task automatic step(bit ret, int fam, bit fl);
    retire_i = ret;
    family_i = 7'(fam);
    flush_i  = fl;
    @(negedge clk_i);
  endtask

  task automatic run_all();
    string tag;
    bit    exp;
    retire_i = 1'b0; family_i = '0; flush_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1", prev_family_o, 0);
    check("R1", paired_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", prev_family_o, 0);
    check("R1", paired_o, 0);

    for (int p = 0; p < 128; p++) begin
      for (int c = 0; c < 128; c++) begin
        step(1'b1, p, 1'b0);
        step(1'b1, c, 1'b0);
        exp = model(p, c, tag);
        check(tag, paired_o, exp);
        check("R2", prev_family_o, c);
        if (((p + c) % 16) == 0) begin
          step(1'b0, (c + 37) % 128, 1'b0);
          check("R9", paired_o, exp);
          check("R9", prev_family_o, c);
        end
      end
    end

    // flush with simultaneous retire: flush wins
    step(1'b1, 32, 1'b0);
    step(1'b1, 3, 1'b0);
    check("R3", paired_o, 1);
    step(1'b1, 3, 1'b1);
    check("R10", prev_family_o, 0);
    check("R10", paired_o, 0);
    step(1'b1, 2, 1'b0);
    check("R10", paired_o, 0);
    check("R10", prev_family_o, 2);
    // flush alone after a paired result
    step(1'b1, 12, 1'b0);
    step(1'b1, 15, 1'b0);
    check("R6", paired_o, 1);
    step(1'b0, 0, 1'b1);
    check("R10", paired_o, 0);
    check("R10", prev_family_o, 0);
    // directional checks
    step(1'b1, 15, 1'b0);
    step(1'b1, 12, 1'b0);
    check("R8", paired_o, 0);
    step(1'b1, 3, 1'b0);
    step(1'b1, 2, 1'b0);
    check("R8", paired_o, 0);
  endtask

  initial begin
    fork
      begin
        run_all();
      end
      begin
        repeat (WATCHDOG) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule